// File: doc/BRIEF.md
# Register Bank with Atomic Set/Clear/Toggle Aliases

This block is a bank of 32-bit memory-mapped registers on a plain single-cycle bus made of an address, a write strobe, a read strobe, write data and read data. Every register occupies a 16-byte window. The first word of the window is the plain location, and the three words after it are aliases. A write to an alias sets, clears or inverts only the bits that are 1 in the write data. Software can then change one field of a shared register in a single bus write, with no read-modify-write sequence that a second bus master could interleave.

Each scalar register is configured at elaboration time with an access type (read-write, read-only or write-only) and a flag that says whether it has aliases. An indexed array of identical registers follows at a configurable base and stride. Every element of the array has its own alias words. Read-only registers show a value supplied by the peripheral logic. All register contents are driven out in parallel to that logic. An optional error output flags illegal accesses.

Top module: `alias_regbank`

## Requirements
- R1: A write at the plain word of a window (address bits [3:2] = 0) replaces the whole register value.
- R2: A write at window word 1 (bits [3:2] = 1) leaves the register equal to old OR data.
- R3: A write at window word 2 (bits [3:2] = 2) leaves the register equal to old AND NOT data.
- R4: A write at window word 3 (bits [3:2] = 3) leaves the register equal to old XOR data.
- R5: A read at the plain word or at any alias word of a readable register returns its current value in the same cycle, with the error output low.
- R6: A read-only register (scalar 2 at 0x020 by default) reads the peripheral input value. Writes to it or to its aliases leave it unchanged and raise the error output.
- R7: A write-only register (scalar 3 at 0x030 by default) reads as zero without error. Plain and alias writes still update its value on the parallel output.
- R8: On a register without aliases (scalar 1 at 0x010 by default), plain writes work. Writes to its alias words change nothing and raise the error output. Reads there return zero with the error output high.
- R9: Array element i sits at ARR_BASE + i*ARR_STEP (0x100 + i*0x10 by default). Each element has its own three aliases, and a write to one element leaves the other elements unchanged.
- R10: An access to an unmapped or misaligned address (bits [1:0] not zero) raises the error output, returns zero and changes no register.
- R11: A synchronous active-low reset sets every writable register to RST_VAL (zero by default).
- R12: Every update is visible on the next cycle, so writes in back-to-back cycles to different aliases of one register both take effect in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data or bit mask for alias writes |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| bus_err | output | 1 | Illegal access flag, valid during the strobed cycle |
| hw_ro_i | input | TOTAL*DATA_W | Peripheral values for read-only slots, slot i in bits [i*DATA_W +: DATA_W] |
| reg_q_o | output | TOTAL*DATA_W | Current value of every slot, same packing |

## Verification
The hardest case to reach from the ports is two alias writes to one register in consecutive cycles, where the second must see the result of the first rather than a stale value. The bench drives strobes on the falling edge and starts each access right after the previous rising edge. Directed back-to-back set and toggle sequences, together with a long random run of accesses with no idle cycles, therefore keep hitting this case. Random addresses also land on the alias words of the register without aliases, on the read-only slot and on unmapped holes. A periodic snapshot of the parallel outputs then confirms that none of those accesses changed anything.

// File: rtl/alias_regbank_pkg.sv
// Package: shared types for the alias register bank.
// Assumes word-aligned 16-byte register windows; the op code is the
// word index inside the window.
package alias_regbank_pkg;

    // Access type of a register slot
    typedef enum logic [1:0] {
        ACC_RW = 2'd0,
        ACC_RO = 2'd1,
        ACC_WO = 2'd2
    } acc_e;

    // Update operation selected by address bits [3:2]
    typedef enum logic [1:0] {
        OP_WR  = 2'd0,
        OP_SET = 2'd1,
        OP_CLR = 2'd2,
        OP_TOG = 2'd3
    } op_e;

endpackage

// File: rtl/alias_addr_decode.sv
// Module: alias_addr_decode
// Turns a bus address into a one-hot slot select and an update op.
// Slots 0..N_SCALAR-1 are scalars at 16-byte stride from 0. The
// remaining slots form the array at ARR_BASE + i*ARR_STEP. It assumes
// ARR_BASE and ARR_STEP are multiples of 16 and that no window overlaps.
// An access counts as legal only when aligned, mapped and using an op
// that the slot permits.
module alias_addr_decode
    import alias_regbank_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter int              N_SCALAR = 4,
    parameter int              ARR_LEN  = 4,
    parameter logic [ADDR_W-1:0] ARR_BASE = 12'h100,
    parameter logic [ADDR_W-1:0] ARR_STEP = 12'h010,
    parameter int              TOTAL    = N_SCALAR + ARR_LEN,
    parameter logic [TOTAL-1:0] SLOT_ALIAS = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [TOTAL-1:0]  sel_o,
    output op_e               op_o,
    output logic              hit_o
);

    localparam int WIN_LSB = 4;

    // Base byte address of slot g
    function automatic logic [ADDR_W-1:0] slot_base(input int g);
        if (g < N_SCALAR)
            return ADDR_W'(g * 16);
        else
            return ARR_BASE + ADDR_W'(g - N_SCALAR) * ARR_STEP;
    endfunction

    logic              aligned;
    logic [TOTAL-1:0]  win_match;
    logic [TOTAL-1:0]  op_allowed;

    // Word alignment and op extraction
    assign aligned = (addr_i[1:0] == 2'b00);
    assign op_o    = op_e'(addr_i[3:2]);

    // Per-slot window compare and alias permission
    for (genvar g = 0; g < TOTAL; g++) begin : g_match
        localparam logic [ADDR_W-1:0] BASE = slot_base(g);
        assign win_match[g]  = aligned &&
                               (addr_i[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]);
        assign op_allowed[g] = SLOT_ALIAS[g] || (addr_i[3:2] == 2'b00);
    end

    // Final select and legality
    assign sel_o = win_match & op_allowed;
    assign hit_o = |sel_o;

    // Windows must never overlap: at most one slot selected (R9)
    assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

    // A select implies an aligned address (R10)
    assert_sel_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (addr_i[1:0] == 2'b00));

endmodule

// File: rtl/alias_reg_slot.sv
// Module: alias_reg_slot
// One register slot. A writable slot holds a flop updated by plain,
// set, clear or toggle writes. A read-only slot passes the peripheral
// value through and has no storage. It assumes wr_en is already
// qualified by decode and access type.
module alias_reg_slot
    import alias_regbank_pkg::*;
#(
    parameter int               DATA_W  = 32,
    parameter acc_e             ACC     = ACC_RW,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  op_e               op,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] hw_in,
    output logic [DATA_W-1:0] q
);

    if (ACC == ACC_RO) begin : g_ro
        logic unused_ro;
        // Read-only: value comes from the peripheral
        assign q         = hw_in;
        assign unused_ro = ^{clk, rst_n, wr_en, op, wdata};
    end else begin : g_rw
        logic [DATA_W-1:0] q_r;
        logic [DATA_W-1:0] q_nxt;
        logic              unused_hw;

        assign unused_hw = ^hw_in;

        // Next-value selection by op
        always_comb begin
            unique case (op)
                OP_WR:   q_nxt = wdata;
                OP_SET:  q_nxt = q_r | wdata;
                OP_CLR:  q_nxt = q_r & ~wdata;
                default: q_nxt = q_r ^ wdata;
            endcase
        end

        // Storage with synchronous active-low reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_r <= RST_VAL;
            else if (wr_en)
                q_r <= q_nxt;
        end

        assign q = q_r;

        assert_plain_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && op == OP_WR) |=> (q == $past(wdata)));
        assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && op == OP_SET) |=> (q == ($past(q) | $past(wdata))));
        assert_clear_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && op == OP_CLR) |=> (q == ($past(q) & ~$past(wdata))));
        assert_toggle_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && op == OP_TOG) |=> (q == ($past(q) ^ $past(wdata))));
        assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(q));
    end

endmodule

// File: rtl/alias_read_mux.sv
// Module: alias_read_mux
// Read-data selection. It ORs the selected slot value onto the bus.
// Write-only slots and unselected slots contribute zero. It assumes
// sel is one-hot or zero.
module alias_read_mux
    import alias_regbank_pkg::*;
#(
    parameter int                 DATA_W   = 32,
    parameter int                 TOTAL    = 8,
    parameter logic [2*TOTAL-1:0] SLOT_ACC = '0
) (
    input  logic [TOTAL-1:0]        sel,
    input  logic [TOTAL*DATA_W-1:0] slot_val,
    output logic [DATA_W-1:0]       rdata
);

    logic [TOTAL-1:0] readable;

    // Which slots may return data
    for (genvar g = 0; g < TOTAL; g++) begin : g_rd
        assign readable[g] = (acc_e'(SLOT_ACC[2*g +: 2]) != ACC_WO);
    end

    // AND-OR read mux
    always_comb begin
        rdata = '0;
        for (int g = 0; g < TOTAL; g++) begin
            if (sel[g] && readable[g])
                rdata = rdata | slot_val[g*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/alias_regbank.sv
// Module: alias_regbank (top)
// Register bank with plain/set/clear/toggle windows per register, a
// configurable scalar section and an indexed array. It assumes one bus
// access per cycle, with bus_wr and bus_rd not both high. Read data and
// the error flag are combinational from the address. Writes take
// effect at the next rising edge.
module alias_regbank
    import alias_regbank_pkg::*;
#(
    parameter int                    DATA_W       = 32,
    parameter int                    ADDR_W       = 12,
    parameter int                    N_SCALAR     = 4,
    parameter logic [2*N_SCALAR-1:0] SCALAR_ACC   = {2'd2, 2'd1, 2'd0, 2'd0},
    parameter logic [N_SCALAR-1:0]   SCALAR_ALIAS = 4'b1101,
    parameter int                    ARR_LEN      = 4,
    parameter logic [ADDR_W-1:0]     ARR_BASE     = 12'h100,
    parameter logic [ADDR_W-1:0]     ARR_STEP     = 12'h010,
    parameter logic [1:0]            ARR_ACC      = 2'd0,
    parameter logic                  ARR_ALIAS    = 1'b1,
    parameter logic [DATA_W-1:0]     RST_VAL      = '0,
    parameter bit                    ERR_EN       = 1'b1,
    parameter int                    TOTAL        = N_SCALAR + ARR_LEN
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    bus_err,
    input  logic [TOTAL*DATA_W-1:0] hw_ro_i,
    output logic [TOTAL*DATA_W-1:0] reg_q_o
);

    // Per-slot access types, scalars then array
    function automatic logic [2*TOTAL-1:0] build_acc();
        logic [2*TOTAL-1:0] v;
        for (int g = 0; g < TOTAL; g++)
            v[2*g +: 2] = (g < N_SCALAR) ? SCALAR_ACC[2*g +: 2] : ARR_ACC;
        return v;
    endfunction

    // Per-slot alias flags, scalars then array
    function automatic logic [TOTAL-1:0] build_alias();
        logic [TOTAL-1:0] v;
        for (int g = 0; g < TOTAL; g++)
            v[g] = (g < N_SCALAR) ? SCALAR_ALIAS[g] : ARR_ALIAS;
        return v;
    endfunction

    localparam logic [2*TOTAL-1:0] SLOT_ACC   = build_acc();
    localparam logic [TOTAL-1:0]   SLOT_ALIAS = build_alias();

    logic [TOTAL-1:0] sel;
    logic [TOTAL-1:0] is_ro;
    logic [TOTAL-1:0] wr_fire;
    op_e              op;
    logic             hit;
    logic             ro_write;

    alias_addr_decode #(
        .ADDR_W    (ADDR_W),
        .N_SCALAR  (N_SCALAR),
        .ARR_LEN   (ARR_LEN),
        .ARR_BASE  (ARR_BASE),
        .ARR_STEP  (ARR_STEP),
        .TOTAL     (TOTAL),
        .SLOT_ALIAS(SLOT_ALIAS)
    ) decode_i (
        .clk   (clk),
        .rst_n (rst_n),
        .addr_i(bus_addr),
        .sel_o (sel),
        .op_o  (op),
        .hit_o (hit)
    );

    // One slot per register
    for (genvar g = 0; g < TOTAL; g++) begin : g_slot
        localparam acc_e ACC = acc_e'(SLOT_ACC[2*g +: 2]);

        assign is_ro[g]   = (ACC == ACC_RO);
        assign wr_fire[g] = bus_wr && sel[g] && !is_ro[g];

        alias_reg_slot #(
            .DATA_W (DATA_W),
            .ACC    (ACC),
            .RST_VAL(RST_VAL)
        ) slot_i (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_en(wr_fire[g]),
            .op   (op),
            .wdata(bus_wdata),
            .hw_in(hw_ro_i[g*DATA_W +: DATA_W]),
            .q    (reg_q_o[g*DATA_W +: DATA_W])
        );

        if (ACC == ACC_WO) begin : g_wo_chk
            assert_wo_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_rd && sel[g]) |-> (bus_rdata == '0));
        end
        if (ACC == ACC_RO) begin : g_ro_chk
            assert_ro_write_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && sel[g]) |-> (bus_err || !ERR_EN));
        end
    end

    alias_read_mux #(
        .DATA_W  (DATA_W),
        .TOTAL   (TOTAL),
        .SLOT_ACC(SLOT_ACC)
    ) rmux_i (
        .sel     (sel),
        .slot_val(reg_q_o),
        .rdata   (bus_rdata)
    );

    assign ro_write = bus_wr && |(sel & is_ro);

    // Optional error flag
    if (ERR_EN) begin : g_err
        assign bus_err = (bus_wr || bus_rd) && (!hit || ro_write);
    end else begin : g_noerr
        logic unused_err;
        assign unused_err = ro_write;
        assign bus_err    = 1'b0;
    end

    // A rejected access updates no slot (R10)
    assert_err_no_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (wr_fire == '0));

    // Miss returns zero read data (R10)
    assert_miss_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit) |-> (bus_rdata == '0));

endmodule

// File: tb/alias_regbank_tb_top.sv
module alias_regbank_tb_top;

    localparam int DW = 32;
    localparam int AW = 12;
    localparam int NS = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [DW-1:0]  bus_wdata = '0;
    logic [DW-1:0]  bus_rdata;
    logic           bus_err;
    logic [NS*DW-1:0] hw_ro_i = '0;
    logic [NS*DW-1:0] reg_q_o;

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] mdl [NS];

    // 0 = read-write, 1 = read-only, 2 = write-only
    int ACC_T [NS] = '{0, 0, 1, 2, 0, 0, 0, 0};
    int ALI_T [NS] = '{1, 0, 1, 1, 1, 1, 1, 1};

    always #10 clk = ~clk;

    alias_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .hw_ro_i(hw_ro_i), .reg_q_o(reg_q_o)
    );

    function automatic int slot_of(logic [AW-1:0] a);
        if (a[1:0] != 2'b00) return -1;
        if (a < 12'h040) return int'(a >> 4);
        if (a >= 12'h100 && a < 12'h140) return 4 + int'((a - 12'h100) >> 4);
        return -1;
    endfunction

    function automatic logic exp_err(logic [AW-1:0] a, logic wr);
        int s = slot_of(a);
        if (s < 0) return 1'b1;
        if (ALI_T[s] == 0 && a[3:2] != 2'b00) return 1'b1;
        if (wr && ACC_T[s] == 1) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [DW-1:0] exp_rd(logic [AW-1:0] a);
        int s = slot_of(a);
        if (exp_err(a, 1'b0)) return '0;
        if (ACC_T[s] == 2) return '0;
        if (ACC_T[s] == 1) return hw_ro_i[s*DW +: DW];
        return mdl[s];
    endfunction

    function automatic logic [DW-1:0] next_val(logic [DW-1:0] o, logic [DW-1:0] d, logic [1:0] op);
        case (op)
            2'd0: return d;
            2'd1: return o | d;
            2'd2: return o & ~d;
            default: return o ^ d;
        endcase
    endfunction

    function automatic logic [AW-1:0] slot_addr(int s, int op);
        logic [AW-1:0] b = (s < 4) ? AW'(s * 16) : AW'(12'h100 + (s - 4) * 16);
        return b | AW'(op << 2);
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_op(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
        int s;
        logic e;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        #5;
        e = exp_err(a, 1'b1);
        check(tag, 32'(bus_err), 32'(e));
        s = slot_of(a);
        if (!e) mdl[s] = next_val(mdl[s], d, a[3:2]);
    endtask

    task automatic rd_op(logic [AW-1:0] a, string tag);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b1;
        #5;
        check(tag, bus_rdata, exp_rd(a));
        check(tag, 32'(bus_err), 32'(exp_err(a, 1'b0)));
    endtask

    task automatic idle_and_snapshot(string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        #5;
        for (int s = 0; s < NS; s++)
            if (ACC_T[s] != 1) check(tag, reg_q_o[s*DW +: DW], mdl[s]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < NS; s++) mdl[s] = '0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        hw_ro_i[2*DW +: DW] = 32'hA5C3_0F96;
        do_reset();

        // R11: reset values
        idle_and_snapshot("R11");
        rd_op(12'h000, "R11");

        // R1..R5 on scalar 0
        wr_op(12'h000, 32'h1234_5678, "R1");
        rd_op(12'h000, "R1");
        wr_op(12'h004, 32'h0000_FF00, "R2");
        rd_op(12'h000, "R2");
        wr_op(12'h008, 32'h0000_0078, "R3");
        rd_op(12'h000, "R3");
        wr_op(12'h00C, 32'hFFFF_0000, "R4");
        rd_op(12'h000, "R4");
        check("R4", mdl[0], 32'hEDCB_FF00);
        rd_op(12'h004, "R5");
        rd_op(12'h008, "R5");
        rd_op(12'h00C, "R5");

        // R12: back-to-back alias writes
        wr_op(12'h004, 32'h0000_000F, "R12");
        wr_op(12'h00C, 32'h0000_0003, "R12");
        wr_op(12'h008, 32'hF000_0000, "R12");
        rd_op(12'h000, "R12");
        check("R12", mdl[0], 32'h0DCB_FF0C);

        // R8: scalar without aliases
        wr_op(12'h010, 32'hCAFE_0001, "R8");
        wr_op(12'h014, 32'hFFFF_FFFF, "R8");
        wr_op(12'h018, 32'hFFFF_FFFF, "R8");
        rd_op(12'h010, "R8");
        rd_op(12'h018, "R8");
        idle_and_snapshot("R8");

        // R6: read-only slot
        rd_op(12'h020, "R6");
        wr_op(12'h020, 32'h0, "R6");
        wr_op(12'h024, 32'hFFFF_FFFF, "R6");
        wr_op(12'h02C, 32'hFFFF_FFFF, "R6");
        rd_op(12'h020, "R6");
        @(negedge clk);
        bus_rd = 1'b0;
        hw_ro_i[2*DW +: DW] = 32'h0BAD_F00D;
        rd_op(12'h028, "R6");

        // R7: write-only slot
        wr_op(12'h030, 32'h0000_0055, "R7");
        rd_op(12'h030, "R7");
        wr_op(12'h034, 32'h0000_0100, "R7");
        rd_op(12'h03C, "R7");
        idle_and_snapshot("R7");
        check("R7", reg_q_o[3*DW +: DW], 32'h0000_0155);

        // R9: array elements
        wr_op(12'h120, 32'h1111_0000, "R9");
        wr_op(12'h124, 32'h0000_2222, "R9");
        wr_op(12'h13C, 32'h8000_0001, "R9");
        rd_op(12'h120, "R9");
        rd_op(12'h130, "R9");
        rd_op(12'h100, "R9");
        idle_and_snapshot("R9");

        // R10: unmapped and misaligned
        wr_op(12'h044, 32'hFFFF_FFFF, "R10");
        wr_op(12'h002, 32'hFFFF_FFFF, "R10");
        wr_op(12'h121, 32'hFFFF_FFFF, "R10");
        rd_op(12'h150, "R10");
        rd_op(12'h0F0, "R10");
        idle_and_snapshot("R10");

        // Random mix, no idle cycles between accesses
        for (int n = 0; n < 1500; n++) begin
            logic [AW-1:0] a;
            int r = int'($urandom_range(0, 9));
            int op = int'($urandom_range(0, 3));
            if (r < 8) a = slot_addr(int'($urandom_range(0, NS - 1)), op);
            else a = AW'($urandom());
            if ($urandom_range(0, 1) == 1) begin
                case (a[3:2])
                    2'd0: wr_op(a, $urandom(), "R1");
                    2'd1: wr_op(a, $urandom(), "R2");
                    2'd2: wr_op(a, $urandom(), "R3");
                    default: wr_op(a, $urandom(), "R4");
                endcase
            end else begin
                rd_op(a, "R5");
            end
            if (n % 100 == 99) idle_and_snapshot("R12");
        end

        // R11: reset mid-run clears state
        do_reset();
        idle_and_snapshot("R11");
        rd_op(12'h120, "R11");

        @(negedge clk);
        bus_rd = 1'b0;
        finish_run();
    end

endmodule